// File: doc/BRIEF.md
# Capability Jump and Privilege Controller

This block decides every control transfer made through a tagged capability word, and it keeps the processor's privilege mode. A capability word is a tag bit plus 64 data bits. The data bits hold a 4-bit permission code in bits 63:60, a 6-bit log2 segment length in bits 59:54 and a 54-bit byte address in bits 53:0. The block holds the current instruction-pointer capability in a register. The privilege mode is not a separate flag. It is decoded from the permission code of that register, so the only way to change it is a legal jump.

Each cycle the block can take a jump request with a target word, a request to turn an integer word into a capability (set its tag), and a notice that a privileged instruction is about to issue. It checks all three against the instruction pointer held at that clock edge. It then registers the new instruction pointer, the result of the tag-set operation and a one-cycle fault pulse with a cause code. Fetch, pipeline control and exception vectoring are done by other blocks.

Top module: `cap_jump_ctrl`

## Requirements
- R1: After synchronous reset the instruction pointer is tag 1, permission 3 (execute-privileged), length 54, address 0. `priv_mode` is 1, `fault_valid` is 0, and the tag-set result is all zero.
- R2: A jump whose target tag is 0 faults with cause 1 (untagged target), whatever its permission field.
- R3: Permission codes are 0 read-only, 1 read/write, 2 execute-user, 3 execute-privileged, 4 enter-user, 5 enter-privileged, 6 key, and 7 to 15 invalid. A tagged jump target with any code other than 2 to 5 faults with cause 2 (bad permission).
- R4: A jump to a tagged enter-user (4) target loads permission 2. A jump to a tagged enter-privileged (5) target loads permission 3. Tag, length and address are kept unchanged.
- R5: A legal jump to an execute target is loaded unchanged, at any address within its segment.
- R6: A jump to an execute-privileged (3) target made from user mode faults with cause 3 (escalation). From privileged mode the same jump is legal.
- R7: `priv_mode` is 1 exactly when the registered instruction-pointer permission is 3. A legal jump to an enter-user or execute-user target leaves privileged mode.
- R8: A privileged-instruction request while `priv_mode` is 0 faults with cause 5. While `priv_mode` is 1 it raises no fault.
- R9: A tag-set request in privileged mode registers the input word with tag 1. In user mode it faults with cause 4 and registers the word unchanged with tag 0. Without a request the tag-set result holds its value.
- R10: A faulting jump leaves the instruction pointer unchanged. Every fault is a single-cycle pulse on `fault_valid`, seen in the cycle after the request, with a nonzero cause.
- R11: When several requests fault in the same cycle, the cause reported is the jump cause, then tag-set (4), then privileged instruction (5). Every check uses the privilege mode held before any jump requested in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jmp_req | input | 1 | Jump request |
| jmp_tag | input | 1 | Tag bit of the jump target |
| jmp_data | input | 64 | Data bits of the jump target |
| setptr_req | input | 1 | Request to set the tag bit of `setptr_data` |
| setptr_data | input | 64 | Integer word to turn into a capability |
| priv_req | input | 1 | A privileged instruction wants to issue |
| ip_tag | output | 1 | Tag bit of the instruction pointer |
| ip_data | output | 64 | Data bits of the instruction pointer |
| priv_mode | output | 1 | 1 when in privileged mode |
| setptr_tag | output | 1 | Tag bit of the last tag-set result |
| setptr_word | output | 64 | Data bits of the last tag-set result |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_cause | output | 3 | Cause code: 0 none, 1 untagged, 2 bad permission, 3 escalation, 4 tag-set in user mode, 5 privileged instruction in user mode |

## Verification
The bench goes after the mode boundary. It jumps from user mode to an execute-privileged word, which a design that only checked permission types would accept, letting a user gain privilege. It raises all three requests in one cycle together with a jump that lowers privilege, to catch a design that checks against the new pointer instead of the old one or that reports the wrong cause. Random targets cover every permission code with both tag values and addresses at both ends of the segment. Each faulting jump is checked for an unchanged pointer, which catches a design that commits the target and only flags it.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int PERM_W  = 4;
    localparam int LEN_W   = 6;
    localparam int ADDR_W  = 54;
    localparam int DATA_W  = PERM_W + LEN_W + ADDR_W;
    localparam int CAUSE_W = 3;

    typedef enum logic [PERM_W-1:0] {
        PERM_RO       = 4'd0,
        PERM_RW       = 4'd1,
        PERM_EXEC_USR = 4'd2,
        PERM_EXEC_PRV = 4'd3,
        PERM_ENTR_USR = 4'd4,
        PERM_ENTR_PRV = 4'd5,
        PERM_KEY      = 4'd6
    } perm_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_UNTAGGED = 3'd1,
        CAUSE_BAD_PERM = 3'd2,
        CAUSE_ESCALATE = 3'd3,
        CAUSE_SETPTR   = 3'd4,
        CAUSE_PRIV_OP  = 3'd5
    } cause_e;

    typedef struct packed {
        logic              tag;
        logic [PERM_W-1:0] perm;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } cap_word_t;

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(ADDR_W);

    function automatic logic is_branch_perm(logic [PERM_W-1:0] p);
        return (p == PERM_EXEC_USR) || (p == PERM_EXEC_PRV) ||
               (p == PERM_ENTR_USR) || (p == PERM_ENTR_PRV);
    endfunction

    function automatic logic [PERM_W-1:0] landing_perm(logic [PERM_W-1:0] p);
        logic [PERM_W-1:0] r;
        case (p)
            PERM_ENTR_USR: r = PERM_EXEC_USR;
            PERM_ENTR_PRV: r = PERM_EXEC_PRV;
            default:       r = p;
        endcase
        return r;
    endfunction

    function automatic cap_word_t reset_ip();
        cap_word_t w;
        w.tag  = 1'b1;
        w.perm = PERM_EXEC_PRV;
        w.len  = FULL_LEN;
        w.addr = '0;
        return w;
    endfunction

endpackage

// File: rtl/cap_target_check.sv
module cap_target_check
    import cap_pkg::*;
(
    input  logic      cur_priv,
    input  cap_word_t target,
    output logic      legal,
    output cause_e    cause,
    output cap_word_t landed
);
    always_comb begin
        legal  = 1'b0;
        cause  = CAUSE_NONE;
        landed = target;
        landed.perm = landing_perm(target.perm);
        if (!target.tag) begin
            cause = CAUSE_UNTAGGED;
        end else if (!is_branch_perm(target.perm)) begin
            cause = CAUSE_BAD_PERM;
        end else if (target.perm == PERM_EXEC_PRV && !cur_priv) begin
            cause = CAUSE_ESCALATE;
        end else begin
            legal = 1'b1;
        end
    end
endmodule

// File: rtl/cap_priv_unit.sv
module cap_priv_unit
    import cap_pkg::*;
(
    input  logic cur_priv,
    input  logic setptr_req,
    input  logic priv_req,
    output logic setptr_grant,
    output logic setptr_fault,
    output logic priv_fault
);
    always_comb begin
        setptr_grant = setptr_req && cur_priv;
        setptr_fault = setptr_req && !cur_priv;
        priv_fault   = priv_req && !cur_priv;
    end
endmodule

// File: rtl/cap_ip_reg.sv
module cap_ip_reg
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  cap_word_t next_ip,
    output cap_word_t ip
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ip <= reset_ip();
        end else if (load) begin
            ip <= next_ip;
        end
    end
endmodule

// File: rtl/cap_jump_ctrl.sv
module cap_jump_ctrl
    import cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              jmp_req,
    input  logic              jmp_tag,
    input  logic [DATA_W-1:0] jmp_data,
    input  logic              setptr_req,
    input  logic [DATA_W-1:0] setptr_data,
    input  logic              priv_req,
    output logic              ip_tag,
    output logic [DATA_W-1:0] ip_data,
    output logic              priv_mode,
    output logic              setptr_tag,
    output logic [DATA_W-1:0] setptr_word,
    output logic              fault_valid,
    output logic [CAUSE_W-1:0] fault_cause
);
    cap_word_t ip_q;
    cap_word_t target;
    cap_word_t landed;
    logic      jmp_legal;
    cause_e    jmp_cause;
    logic      sp_grant;
    logic      sp_fault;
    logic      pv_fault;
    cause_e    cause_d;
    cause_e    cause_q;
    logic      fault_q;
    logic      sp_tag_q;
    logic [DATA_W-1:0] sp_word_q;

    assign target    = cap_word_t'({jmp_tag, jmp_data});
    assign priv_mode = (ip_q.perm == PERM_EXEC_PRV);

    cap_target_check u_target (
        .cur_priv (priv_mode),
        .target   (target),
        .legal    (jmp_legal),
        .cause    (jmp_cause),
        .landed   (landed)
    );

    cap_priv_unit u_priv (
        .cur_priv     (priv_mode),
        .setptr_req   (setptr_req),
        .priv_req     (priv_req),
        .setptr_grant (sp_grant),
        .setptr_fault (sp_fault),
        .priv_fault   (pv_fault)
    );

    cap_ip_reg u_ip (
        .clk     (clk),
        .rst     (rst),
        .load    (jmp_req && jmp_legal),
        .next_ip (landed),
        .ip      (ip_q)
    );

    // Fault priority: jump first, then tag-set, then privileged op.
    always_comb begin
        if (jmp_req && !jmp_legal) begin
            cause_d = jmp_cause;
        end else if (sp_fault) begin
            cause_d = CAUSE_SETPTR;
        end else if (pv_fault) begin
            cause_d = CAUSE_PRIV_OP;
        end else begin
            cause_d = CAUSE_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q   <= 1'b0;
            cause_q   <= CAUSE_NONE;
            sp_tag_q  <= 1'b0;
            sp_word_q <= '0;
        end else begin
            fault_q <= (cause_d != CAUSE_NONE);
            cause_q <= cause_d;
            if (setptr_req) begin
                sp_tag_q  <= sp_grant;
                sp_word_q <= setptr_data;
            end
        end
    end

    assign ip_tag      = ip_q.tag;
    assign ip_data     = {ip_q.perm, ip_q.len, ip_q.addr};
    assign setptr_tag  = sp_tag_q;
    assign setptr_word = sp_word_q;
    assign fault_valid = fault_q;
    assign fault_cause = cause_q;

endmodule

// File: rtl/cap_jump_ctrl_chk.sv
module cap_jump_ctrl_chk
    import cap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              jmp_req,
    input logic              jmp_tag,
    input logic [DATA_W-1:0] jmp_data,
    input logic              setptr_req,
    input logic              priv_req,
    input logic              ip_tag,
    input logic [DATA_W-1:0] ip_data,
    input logic              priv_mode,
    input logic              setptr_tag,
    input logic              fault_valid,
    input logic [CAUSE_W-1:0] fault_cause
);
    localparam int PH = DATA_W - 1;
    localparam int PL = DATA_W - PERM_W;

    // R10: a jump fault leaves the pointer where it was
    p_fault_keeps_ip_r10: assert property (@(posedge clk) disable iff (rst)
        (fault_valid && fault_cause >= 3'd1 && fault_cause <= 3'd3)
            |-> (ip_data == $past(ip_data) && ip_tag == $past(ip_tag)));

    // R10: a fault always carries a cause
    p_fault_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> fault_cause != 3'd0);

    // R4: enter-user lands as execute-user at the same address
    p_enter_user_lands_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(jmp_req && jmp_tag && jmp_data[PH:PL] == 4'd4))
            |-> (ip_data[PH:PL] == 4'd2 && ip_data[PL-1:0] == $past(jmp_data[PL-1:0])));

    // R6: privilege is gained only through an enter-privileged jump
    p_no_escalation_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(priv_mode) && priv_mode)
            |-> $past(jmp_req && jmp_tag && jmp_data[PH:PL] == 4'd5));

    // R9: a user-mode tag-set faults and yields an untagged word
    p_setptr_user_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(setptr_req && !priv_mode)) |-> (fault_valid && !setptr_tag));

    // R8: a privileged op from user mode always faults
    p_priv_op_user_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(priv_req && !priv_mode)) |-> fault_valid);
endmodule

bind cap_jump_ctrl cap_jump_ctrl_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .jmp_req     (jmp_req),
    .jmp_tag     (jmp_tag),
    .jmp_data    (jmp_data),
    .setptr_req  (setptr_req),
    .priv_req    (priv_req),
    .ip_tag      (ip_tag),
    .ip_data     (ip_data),
    .priv_mode   (priv_mode),
    .setptr_tag  (setptr_tag),
    .fault_valid (fault_valid),
    .fault_cause (fault_cause)
);

// File: tb/test_cap_jump_ctrl.sv
module test_cap_jump_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        jmp_req = 1'b0;
    logic        jmp_tag = 1'b0;
    logic [63:0] jmp_data = '0;
    logic        setptr_req = 1'b0;
    logic [63:0] setptr_data = '0;
    logic        priv_req = 1'b0;
    logic        ip_tag;
    logic [63:0] ip_data;
    logic        priv_mode;
    logic        setptr_tag;
    logic [63:0] setptr_word;
    logic        fault_valid;
    logic [2:0]  fault_cause;

    int n_tests = 0;
    int n_fail  = 0;

    logic [64:0] m_ip;
    logic        m_sp_tag;
    logic [63:0] m_sp_word;

    always #2 clk = ~clk;

    cap_jump_ctrl i_cap_jump_ctrl (
        .clk(clk), .rst(rst), .jmp_req(jmp_req), .jmp_tag(jmp_tag),
        .jmp_data(jmp_data), .setptr_req(setptr_req), .setptr_data(setptr_data),
        .priv_req(priv_req), .ip_tag(ip_tag), .ip_data(ip_data),
        .priv_mode(priv_mode), .setptr_tag(setptr_tag), .setptr_word(setptr_word),
        .fault_valid(fault_valid), .fault_cause(fault_cause)
    );

    function automatic logic [63:0] mk(logic [3:0] p, logic [5:0] l, logic [53:0] a);
        return {p, l, a};
    endfunction

    task automatic check(string req, logic [64:0] act, logic [64:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request cycle: model the expected result, clock, compare.
    task automatic step(string req, logic jr, logic jt, logic [63:0] jd,
                        logic sr, logic [63:0] sd, logic pr);
        logic       mpriv;
        logic [3:0] tp;
        logic [2:0] jc;
        logic [2:0] ec;
        mpriv = (m_ip[63:60] == 4'd3);
        tp = jd[63:60];
        jc = 3'd0;
        if (jr) begin
            if (!jt) jc = 3'd1;
            else if (tp < 4'd2 || tp > 4'd5) jc = 3'd2;
            else if (tp == 4'd3 && !mpriv) jc = 3'd3;
        end
        if (jc != 3'd0) ec = jc;
        else if (sr && !mpriv) ec = 3'd4;
        else if (pr && !mpriv) ec = 3'd5;
        else ec = 3'd0;
        @(negedge clk);
        jmp_req = jr; jmp_tag = jt; jmp_data = jd;
        setptr_req = sr; setptr_data = sd; priv_req = pr;
        @(posedge clk);
        #1;
        jmp_req = 1'b0; setptr_req = 1'b0; priv_req = 1'b0;
        if (jr && jc == 3'd0) begin
            m_ip = {jt, jd};
            if (tp == 4'd4) m_ip[63:60] = 4'd2;
            if (tp == 4'd5) m_ip[63:60] = 4'd3;
        end
        if (sr) begin
            m_sp_tag = mpriv;
            m_sp_word = sd;
        end
        check({req, " ip"}, {ip_tag, ip_data}, m_ip);
        check({req, " R7 mode"}, 65'(priv_mode), 65'(m_ip[63:60] == 4'd3));
        check({req, " fault"}, 65'({fault_valid, fault_cause}), 65'({ec != 3'd0, ec}));
        check({req, " R9 setptr"}, {setptr_tag, setptr_word}, {m_sp_tag, m_sp_word});
        // R10: the pulse drops on an idle cycle
        @(posedge clk);
        #1;
        check({req, " R10 pulse"}, 65'(fault_valid), 65'd0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        m_ip = {1'b1, mk(4'd3, 6'd54, '0)};
        m_sp_tag = 1'b0;
        m_sp_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset ip", {ip_tag, ip_data}, m_ip);
        check("R1 reset mode", 65'(priv_mode), 65'd1);
        check("R1 reset fault", 65'(fault_valid), 65'd0);
        check("R1 reset setptr", {setptr_tag, setptr_word}, 65'd0);

        step("R8 priv op in priv mode", 0, 0, '0, 0, '0, 1);
        step("R9 setptr priv", 0, 0, '0, 1, 64'h0123_4567_89ab_cdef, 0);
        step("R2 untagged exec", 1, 0, mk(4'd2, 6'd8, 54'h100), 0, '0, 0);
        step("R3 key target", 1, 1, mk(4'd6, 6'd8, 54'h100), 0, '0, 0);
        step("R3 invalid code", 1, 1, mk(4'd15, 6'd8, 54'h100), 0, '0, 0);
        step("R6 exec-priv from priv", 1, 1, mk(4'd3, 6'd12, 54'hfff), 0, '0, 0);
        step("R4 enter-user", 1, 1, mk(4'd4, 6'd12, 54'h3000), 0, '0, 0);
        step("R8 priv op in user", 0, 0, '0, 0, '0, 1);
        step("R9 setptr user", 0, 0, '0, 1, 64'hfeed_0000_0000_0001, 0);
        step("R6 exec-priv from user", 1, 1, mk(4'd3, 6'd12, 54'h3000), 0, '0, 0);
        step("R5 exec-user top of seg", 1, 1, mk(4'd2, 6'd12, 54'h3fff), 0, '0, 0);
        step("R11 mixed user faults", 1, 1, mk(4'd5, 6'd4, 54'h40), 1, 64'h5, 1);
        step("R11 jump wins", 1, 1, mk(4'd0, 6'd4, 54'h40), 1, 64'h6, 1);
        step("R11 old mode used", 1, 1, mk(4'd4, 6'd4, 54'h80), 1, 64'h7, 1);
        step("R4 enter-priv", 1, 1, mk(4'd5, 6'd20, 54'h100000), 0, '0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  p;
            logic [5:0]  l;
            logic [53:0] a;
            p = 4'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) p = 4'($urandom_range(8, 15));
            l = 6'($urandom_range(0, 54));
            a = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) a = '0;
            step("R5 random", $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0,
                 mk(p, l, a), $urandom_range(0, 3) == 0, {$urandom, $urandom},
                 $urandom_range(0, 3) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule